// File: doc/BRIEF.md
# Memory-Mapped Pin Bank Controller

This block drives twenty general-purpose pins from a register bus with 64-bit data. Each pin has a drive-value flop, the output latch, and a direction flop, the output enable. Both go to outside pad logic. The pad levels come back in through a two-stage synchronizer. Software reads them as a single word, with pin n at bit n.

The drive values change only through two write ports. A write to the set port turns on every latch whose data bit is 1. A write to the clear port turns off every latch whose data bit is 1. Pins whose data bit is 0 are untouched in both cases, so no read-modify-write is needed. Each pin also has its own configuration word, whose bit 0 is the output enable. These words sit at an 8-byte stride, with a jump in the map after pin 15.

A latch can be loaded while its pin is still an input. Turning the enable on later then drives the value already loaded, never an older level.

Top module: `pin_bank_ctrl`

## Requirements
- R1: While reset is held, and on leaving it, every output latch, every output enable and the read data are zero.
- R2: A write to offset 0x88 sets the latch of each pin whose data bit is 1. Pins whose bit is 0 keep their latch. The pin outputs show the new value on the clock after the write.
- R3: A write to offset 0x90 clears the latch of each pin whose data bit is 1. Pins whose bit is 0 keep their latch.
- R4: For pins 0 to 15, the configuration word is at offset 8*n. Bit 0 of the word is the output enable and drives the pin's enable output. A read of the word returns the enable in bit 0, with every other bit zero.
- R5: For pins 16 to 19, the configuration word is at offset 0x100 + 8*(n-16). Offsets 0x80 to 0xF8 reach no configuration word.
- R6: A read of offset 0x80 returns the pad level of pin n at bit n, after a two-flop synchronizer. A level applied before clock edge k is returned by a read issued on edge k+2.
- R7: Loading a latch does not change any output enable, and writing a configuration word does not change any latch. A pin enabled after its latch was loaded drives the loaded value.
- R8: A read of offset 0x88 or 0x90 returns the current latch values.
- R9: Reads of unmapped offsets return zero. Writes to unmapped offsets, including any offset not a multiple of 8 and the read-only offset 0x80, change neither latches nor enables.
- R10: Bits 20 to 63 of the set and clear write data have no effect. Bits 20 to 63 of every read word are zero.
- R11: Read data is registered. It holds the addressed value on the clock after a cycle with the read enable high, and is zero after a cycle with the read enable low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for this cycle |
| rdEn | input | 1 | Read strobe for this cycle |
| addr | input | 9 | Byte offset of the access |
| wrData | input | 64 | Write data |
| rdData | output | 64 | Registered read data |
| padIn | input | 20 | Pad input levels, asynchronous |
| padOut | output | 20 | Drive value for each pin |
| padOe | output | 20 | Output enable for each pin |

## Verification
Latch and enable writes appear on the pin outputs one clock after the write cycle. Read data appears one clock after the read cycle. A pad level shows up in a pins read issued two edges after the level was applied. The reference model in the bench has matching registered stages, and every output is compared two nanoseconds after each rising edge. Directed reads take their samples one nanosecond after the capturing edge. The synchronizer test checks both the stale read one edge too early and the fresh read on the due edge.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;

  typedef enum logic [1:0] {
    RD_ZERO  = 2'd0,
    RD_PINS  = 2'd1,
    RD_LATCH = 2'd2,
    RD_CFG   = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic   setStb;
    logic   clrStb;
    logic   cfgWr;
    logic   rdStb;
    rdSrc_e rdSrc;
  } bankStb_t;

endpackage

// File: rtl/pin_bank_decode.sv
module pin_bank_decode
  import pin_bank_pkg::*;
#(
  parameter int NUM_LINES = 20,
  parameter int ADDR_W    = 9,
  parameter int LOW_BANK  = 16,
  parameter int STRIDE    = 8,
  parameter int HIGH_BASE = 256,
  parameter int PINS_OFS  = 128,
  parameter int SET_OFS   = 136,
  parameter int CLR_OFS   = 144,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output bankStb_t          stb,
  output logic [IDX_W-1:0]  lineIdx
);

  localparam logic [ADDR_W-1:0] PinsAddr = ADDR_W'(PINS_OFS);
  localparam logic [ADDR_W-1:0] SetAddr  = ADDR_W'(SET_OFS);
  localparam logic [ADDR_W-1:0] ClrAddr  = ADDR_W'(CLR_OFS);

  // configuration word offset of one pin, with the jump after the low bank
  function automatic logic [ADDR_W-1:0] cfgAddr(input int n);
    if (n < LOW_BANK) return ADDR_W'(STRIDE * n);
    return ADDR_W'(HIGH_BASE + STRIDE * (n - LOW_BANK));
  endfunction

  logic cfgHit;
  logic latchHit;

  always_comb begin
    cfgHit  = 1'b0;
    lineIdx = '0;
    for (int n = 0; n < NUM_LINES; n++) begin
      if (addr == cfgAddr(n)) begin
        cfgHit  = 1'b1;
        lineIdx = IDX_W'(n);
      end
    end
  end

  assign latchHit = (addr == SetAddr) || (addr == ClrAddr);

  always_comb begin
    stb.setStb = wrEn && (addr == SetAddr);
    stb.clrStb = wrEn && (addr == ClrAddr);
    stb.cfgWr  = wrEn && cfgHit;
    stb.rdStb  = rdEn;
    if (addr == PinsAddr)  stb.rdSrc = RD_PINS;
    else if (latchHit)     stb.rdSrc = RD_LATCH;
    else if (cfgHit)       stb.rdSrc = RD_CFG;
    else                   stb.rdSrc = RD_ZERO;
  end

endmodule

// File: rtl/pin_bank_sync.sv
module pin_bank_sync #(
  parameter int WIDTH  = 20,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/pin_bank_datapath.sv
module pin_bank_datapath
  import pin_bank_pkg::*;
#(
  parameter int NUM_LINES   = 20,
  parameter int DATA_W      = 64,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bankStb_t             stb,
  input  logic [IDX_W-1:0]     lineIdx,
  input  logic [NUM_LINES-1:0] wrBits,
  input  logic [NUM_LINES-1:0] padIn,
  output logic [NUM_LINES-1:0] padOut,
  output logic [NUM_LINES-1:0] padOe,
  output logic [DATA_W-1:0]    rdData
);

  logic [NUM_LINES-1:0] outLatch;
  logic [NUM_LINES-1:0] oeReg;
  logic [NUM_LINES-1:0] pinLevel;

  pin_bank_sync #(
    .WIDTH (NUM_LINES),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (padIn),
    .dout(pinLevel)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           outLatch <= '0;
    else if (stb.setStb) outLatch <= outLatch | wrBits;
    else if (stb.clrStb) outLatch <= outLatch & ~wrBits;
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                     oeReg[g] <= 1'b0;
      else if (stb.cfgWr && (lineIdx == IDX_W'(g)))  oeReg[g] <= wrBits[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.rdStb) begin
      case (stb.rdSrc)
        RD_PINS:  rdData <= DATA_W'(pinLevel);
        RD_LATCH: rdData <= DATA_W'(outLatch);
        RD_CFG:   rdData <= DATA_W'(oeReg[lineIdx]);
        default:  rdData <= '0;
      endcase
    end else begin
      rdData <= '0;
    end
  end

  assign padOut = outLatch;
  assign padOe  = oeReg;

endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pin_bank_pkg::*;
#(
  parameter int NUM_LINES   = 20,
  parameter int DATA_W      = 64,
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic [NUM_LINES-1:0] padIn,
  output logic [NUM_LINES-1:0] padOut,
  output logic [NUM_LINES-1:0] padOe
);

  bankStb_t         stb;
  logic [IDX_W-1:0] lineIdx;
  logic             unusedHiBits;

  // write data above the pin count never reaches a register
  assign unusedHiBits = ^wrData[DATA_W-1:NUM_LINES];

  pin_bank_decode #(
    .NUM_LINES(NUM_LINES),
    .ADDR_W   (ADDR_W)
  ) u_decode (
    .addr   (addr),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .stb    (stb),
    .lineIdx(lineIdx)
  );

  pin_bank_datapath #(
    .NUM_LINES  (NUM_LINES),
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .lineIdx(lineIdx),
    .wrBits (wrData[NUM_LINES-1:0]),
    .padIn  (padIn),
    .padOut (padOut),
    .padOe  (padOe),
    .rdData (rdData)
  );

endmodule

// File: rtl/pin_bank_chk.sv
module pin_bank_chk #(
  parameter int NUM_LINES = 20,
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 9
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic                 rdEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wrData,
  input logic [DATA_W-1:0]    rdData,
  input logic [NUM_LINES-1:0] padOut,
  input logic [NUM_LINES-1:0] padOe
);

  logic isSet;
  logic isClr;
  logic isMapped;

  assign isSet = (addr == ADDR_W'(136));
  assign isClr = (addr == ADDR_W'(144));
  assign isMapped = isSet || isClr || (addr[2:0] == 3'd0 &&
                    (addr < ADDR_W'(128) || (addr >= ADDR_W'(256) && addr < ADDR_W'(288))));

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isSet) |=> ((padOut & $past(wrData[NUM_LINES-1:0])) == $past(wrData[NUM_LINES-1:0])));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isClr) |=> ((padOut & $past(wrData[NUM_LINES-1:0])) == '0));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (isSet || isClr)) |=> $stable(padOut));

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !isMapped) |=> ($stable(padOut) && $stable(padOe)));

  // R10
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> (rdData[DATA_W-1:NUM_LINES] == '0));

  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdData == '0));

endmodule

bind pin_bank_ctrl pin_bank_chk #(
  .NUM_LINES(NUM_LINES),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .wrEn  (wrEn),
  .rdEn  (rdEn),
  .addr  (addr),
  .wrData(wrData),
  .rdData(rdData),
  .padOut(padOut),
  .padOe (padOe)
);

// File: tb/pin_bank_ctrl_tb.sv
`timescale 1ns/1ps
module pin_bank_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [8:0]  addr = '0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic [19:0] padIn = '0;
  logic [19:0] padOut;
  logic [19:0] padOe;

  int    errors = 0;
  int    checks = 0;
  bit    started = 0;
  bit    finished = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  pin_bank_ctrl u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  // behavioural reference model
  logic [19:0] mOut, mOe, mS1, mS2;
  logic [63:0] mRd;
  int ln;

  function automatic int cfgLine(input logic [8:0] a);
    int v = int'(a);
    if (v % 8 != 0) return -1;
    if (v < 128) return v / 8;
    if (v >= 256 && v < 288) return 16 + (v - 256) / 8;
    return -1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mOut <= '0; mOe <= '0; mS1 <= '0; mS2 <= '0; mRd <= '0;
    end else begin
      mS1 <= padIn;
      mS2 <= mS1;
      ln = cfgLine(addr);
      if (wrEn) begin
        if (addr == 9'h088)      mOut <= mOut | wrData[19:0];
        else if (addr == 9'h090) mOut <= mOut & ~wrData[19:0];
        else if (ln >= 0)        mOe[ln] <= wrData[0];
      end
      if (!rdEn)                                  mRd <= '0;
      else if (addr == 9'h080)                    mRd <= {44'd0, mS2};
      else if (addr == 9'h088 || addr == 9'h090)  mRd <= {44'd0, mOut};
      else if (ln >= 0)                           mRd <= {63'd0, mOe[ln]};
      else                                        mRd <= '0;
    end
  end

  always @(posedge clk) begin
    #2;
    if (started && rstN && !finished) begin
      checks++;
      if (padOut !== mOut || padOe !== mOe || rdData !== mRd) begin
        errors++;
        $display("FAIL %s model: out=%h oe=%h rd=%h expected out=%h oe=%h rd=%h",
                 curReq, padOut, padOe, rdData, mOut, mOe, mRd);
      end
    end
  end

  task automatic expect64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [8:0] a, input logic [63:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [8:0] a, output logic [63:0] v);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(posedge clk); #1;
    v = rdData;
    rdEn = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(posedge clk);
    #1;
    // R1
    expect64("R1", {44'd0, padOut}, 64'd0);
    expect64("R1", {44'd0, padOe}, 64'd0);
    expect64("R1", rdData, 64'd0);
    @(negedge clk); rstN = 1'b1; started = 1;
    @(posedge clk); #1;
    expect64("R1", {24'd0, padOut, padOe}, 64'd0);

    curReq = "R2";
    doWrite(9'h088, 64'hFFFF_FFFF_FFF1_0005);
    expect64("R2", {44'd0, padOut}, 64'h10005);   // R10 upper bits ignored
    doWrite(9'h088, 64'h0000_0000_0000_0300);
    expect64("R2", {44'd0, padOut}, 64'h10305);

    curReq = "R3";
    doWrite(9'h090, 64'hFFFF_FFFF_FFF0_0104);
    expect64("R3", {44'd0, padOut}, 64'h10201);

    curReq = "R8";
    doRead(9'h088, v); expect64("R8", v, 64'h10201);
    doRead(9'h090, v); expect64("R8", v, 64'h10201);
    @(posedge clk); #1;
    expect64("R11", rdData, 64'd0);

    curReq = "R7";
    doWrite(9'h088, 64'h8);
    expect64("R7", {44'd0, padOe}, 64'd0);
    doWrite(9'h018, 64'h1);
    expect64("R7", {44'd0, padOe}, 64'h8);
    expect64("R7", {44'd0, padOut}, 64'h10209);

    curReq = "R4";
    doRead(9'h018, v); expect64("R4", v, 64'h1);
    doWrite(9'h018, 64'hFFFF_FFFF_FFFF_FFFE);
    expect64("R4", {44'd0, padOe}, 64'h0);
    doWrite(9'h018, 64'hFFFF_FFFF_FFFF_FFFF);
    doRead(9'h018, v); expect64("R4", v, 64'h1);
    doWrite(9'h078, 64'h1);
    expect64("R4", {44'd0, padOe}, 64'h08008);

    curReq = "R5";
    doWrite(9'h108, 64'h1);
    doWrite(9'h118, 64'h1);
    expect64("R5", {44'd0, padOe}, 64'hA8008);
    doRead(9'h108, v); expect64("R5", v, 64'h1);
    doWrite(9'h0A0, 64'hFFFF);
    expect64("R5", {44'd0, padOe}, 64'hA8008);

    curReq = "R9";
    doWrite(9'h0F8, '1);
    doWrite(9'h120, '1);
    doWrite(9'h00C, '1);
    doWrite(9'h080, '1);
    expect64("R9", {24'd0, padOut, padOe}, {24'd0, 20'h10209, 20'hA8008});
    doRead(9'h098, v); expect64("R9", v, 64'd0);
    doRead(9'h00C, v); expect64("R9", v, 64'd0);

    curReq = "R6";
    @(negedge clk); padIn = 20'hA5A5A;
    doRead(9'h080, v); expect64("R6", v, 64'd0);
    doRead(9'h080, v); expect64("R6", v, 64'hA5A5A);   // R10 upper zero
    @(negedge clk); padIn = 20'h5A5A5;
    doRead(9'h080, v); expect64("R6", v, 64'hA5A5A);
    doRead(9'h080, v); expect64("R6", v, 64'h5A5A5);

    curReq = "R11";
    for (int i = 0; i < 400; i++) begin
      logic [8:0] a;
      int pick = $urandom_range(0, 9);
      case (pick)
        0: a = 9'h080; 1: a = 9'h088; 2: a = 9'h090;
        3: a = 9'(8 * $urandom_range(0, 15));
        4: a = 9'(256 + 8 * $urandom_range(0, 3));
        5: a = 9'($urandom_range(0, 511));
        default: a = 9'(8 * $urandom_range(0, 40));
      endcase
      @(negedge clk);
      addr = a;
      wrData = {$urandom, $urandom};
      wrEn = ($urandom_range(0, 2) == 0);
      rdEn = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 5) == 0) padIn = 20'($urandom);
    end
    @(negedge clk); wrEn = 1'b0; rdEn = 1'b0;
    repeat (4) @(posedge clk);
    #3;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule